// File: doc/BRIEF.md
# Injected Conversion Group Sequencer

This block controls a short, high-priority list of conversions that runs beside an ordinary ADC scan. Software programs up to four ranks, each naming a channel and an offset, plus a group length. A start comes from a software pulse, from a selected external event line (after a two-stage synchronizer, on a programmable edge), or from the completion of the regular scan when automatic chaining is enabled. The sequencer then hands channel numbers one by one to a conversion engine through a request/done handshake.

Each returned sample is reduced to the active resolution and has the rank's offset taken away, with the result clamped at zero. It is then kept in a per-rank result register. A one-cycle pulse marks every finished rank and a sticky flag marks the finished group. A discontinuous mode splits the group so that each start converts a single rank.

Top module: `adc_inj_sequencer`

## Requirements
- R1: `cfg_len_m1` holds the group length minus one (0..3 gives 1..4 ranks). With scan on, a start converts rank 0 first and then each higher rank up to the length, and `conv_chan` shows the channel of the rank being requested.
- R2: With an external source selected, the chosen line passes through two synchronizing flops, and `cfg_edge` picks the edge that starts a group: 00 none, 01 rising, 10 falling, 11 either.
- R3: A `cfg_src` value equal to NSRC (4 by default) selects software start. Only then does `sw_start` launch a group, and while it is selected the external lines have no effect. With a value below NSRC, `sw_start` is ignored.
- R4: Any start that arrives while a group or rank is in progress is dropped.
- R5: In discontinuous mode each start converts exactly one rank, moving up one rank per start, and the start after the last rank returns to rank 0.
- R6: Discontinuous mode is in force only when `cfg_scan`=1 and `cfg_cont`=0; otherwise every start runs the whole group.
- R7: With `cfg_scan`=0 each start converts only rank 0, whatever the length.
- R8: A `reg_done` pulse starts the group only when `cfg_auto`=1, software start is selected and discontinuous mode is not in force; in every other case it is ignored.
- R9: The stored result is (raw AND mask) minus (offset AND mask), or 0 when that difference is negative. The mask follows `cfg_res`: 00 12 bits, 01 10 bits, 10 8 bits, 11 6 bits.
- R10: `eoc` is high for exactly the one cycle after each accepted `conv_done`, and `conv_req` stays high until the engine answers.
- R11: `eog` is set after the last rank of a group and stays set until `eog_clr`; a set in the same cycle takes precedence over the clear.
- R12: After reset there is no request, no `eoc`, no `eog`, and every result register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len_m1 | input | 2 | Group length minus one |
| cfg_chan | input | 20 | Channel of each rank, 5 bits per rank, rank 0 in the low bits |
| cfg_offset | input | 48 | Offset of each rank, 12 bits per rank, rank 0 in the low bits |
| cfg_res | input | 2 | Resolution select |
| cfg_src | input | 3 | Start source; the value 4 means software |
| cfg_edge | input | 2 | External edge select |
| cfg_scan | input | 1 | Sequencer enable |
| cfg_cont | input | 1 | Continuous conversion active |
| cfg_disc | input | 1 | Discontinuous request |
| cfg_auto | input | 1 | Chain after regular scan |
| ext_trig | input | 4 | External event lines |
| sw_start | input | 1 | Software start pulse |
| reg_done | input | 1 | Regular scan complete pulse |
| conv_req | output | 1 | Conversion request |
| conv_chan | output | 5 | Channel to convert |
| conv_done | input | 1 | Conversion finished pulse |
| conv_data | input | 12 | Raw conversion result |
| data_out | output | 48 | Result registers, 12 bits per rank, rank 0 in the low bits |
| eoc | output | 1 | Rank finished pulse |
| eog | output | 1 | Sticky group finished flag |
| eog_clr | input | 1 | Clear for `eog` |

## Verification
The bench builds the block at its defaults: four ranks, four event lines, 12-bit data and 5-bit channel numbers. With these values every group length from one to four can be reached. The software code 4 sits just above the external lines, so both source kinds and the boundary between them are covered. All four resolution masks apply to real 12-bit samples, and one offset equals full scale, which forces the clamp to zero for every rank that uses it.

// File: rtl/inj_seq_pkg.sv
package inj_seq_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic scan;
        logic cont;
        logic disc;
        logic chain;
    } grp_mode_t;

    function automatic logic edge_hit(edge_mode_e mode, logic cur, logic prev);
        logic hit;
        unique case (mode)
            EDGE_RISE: hit = cur & ~prev;
            EDGE_FALL: hit = ~cur & prev;
            EDGE_ANY:  hit = cur ^ prev;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/inj_trig_detect.sv
module inj_trig_detect
    import inj_seq_pkg::*;
#(
    parameter int NSRC  = 4,
    parameter int SRC_W = $clog2(NSRC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  ext_trig,
    input  logic [SRC_W-1:0] cfg_src,
    input  logic [1:0]       cfg_edge,
    input  logic             sw_start,
    output logic             sw_sel,
    output logic             fire
);
    logic line_sel;
    logic [2:0] sync_q;

    always_comb begin
        line_sel = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (cfg_src == SRC_W'(i)) line_sel = ext_trig[i];
        end
    end

    assign sw_sel = (cfg_src == SRC_W'(NSRC));

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], line_sel};
    end

    assign fire = sw_sel ? sw_start
                         : edge_hit(edge_mode_e'(cfg_edge), sync_q[1], sync_q[2]);
endmodule

// File: rtl/inj_offset_sat.sv
module inj_offset_sat #(
    parameter int DW = 12
) (
    input  logic [DW-1:0] raw,
    input  logic [DW-1:0] offset,
    input  logic [1:0]    res,
    output logic [DW-1:0] result
);
    logic [DW-1:0] mask;
    logic [DW-1:0] raw_m;
    logic [DW-1:0] off_m;

    assign mask   = {DW{1'b1}} >> (2 * res);
    assign raw_m  = raw & mask;
    assign off_m  = offset & mask;
    assign result = (raw_m > off_m) ? (raw_m - off_m) : '0;
endmodule

// File: rtl/adc_inj_sequencer.sv
module adc_inj_sequencer
    import inj_seq_pkg::*;
#(
    parameter int NRANK = 4,
    parameter int NSRC  = 4,
    parameter int DW    = 12,
    parameter int CH_W  = 5,
    localparam int LEN_W = (NRANK > 1) ? $clog2(NRANK) : 1,
    localparam int SRC_W = $clog2(NSRC + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LEN_W-1:0]      cfg_len_m1,
    input  logic [NRANK*CH_W-1:0] cfg_chan,
    input  logic [NRANK*DW-1:0]   cfg_offset,
    input  logic [1:0]            cfg_res,
    input  logic [SRC_W-1:0]      cfg_src,
    input  logic [1:0]            cfg_edge,
    input  logic                  cfg_scan,
    input  logic                  cfg_cont,
    input  logic                  cfg_disc,
    input  logic                  cfg_auto,
    input  logic [NSRC-1:0]       ext_trig,
    input  logic                  sw_start,
    input  logic                  reg_done,
    output logic                  conv_req,
    output logic [CH_W-1:0]       conv_chan,
    input  logic                  conv_done,
    input  logic [DW-1:0]         conv_data,
    output logic [NRANK*DW-1:0]   data_out,
    output logic                  eoc,
    output logic                  eog,
    input  logic                  eog_clr
);
    grp_mode_t        mode;
    logic             sw_sel;
    logic             fire;
    logic             disc_eff;
    logic             auto_go;
    logic             start;
    logic             accept;
    logic             at_last;
    logic [LEN_W-1:0] eff_last;
    logic [LEN_W-1:0] idx;
    logic             busy;
    logic [CH_W-1:0]  chan_arr [NRANK];
    logic [DW-1:0]    off_arr  [NRANK];
    logic [DW-1:0]    result;

    assign mode = '{scan: cfg_scan, cont: cfg_cont, disc: cfg_disc, chain: cfg_auto};

    inj_trig_detect #(.NSRC(NSRC), .SRC_W(SRC_W)) u_trig (
        .clk      (clk),
        .rst      (rst),
        .ext_trig (ext_trig),
        .cfg_src  (cfg_src),
        .cfg_edge (cfg_edge),
        .sw_start (sw_start),
        .sw_sel   (sw_sel),
        .fire     (fire)
    );

    assign disc_eff = mode.disc & mode.scan & ~mode.cont;
    assign eff_last = mode.scan ? cfg_len_m1 : '0;
    assign auto_go  = mode.chain & sw_sel & ~disc_eff & reg_done;
    assign start    = ~busy & (fire | auto_go);
    assign accept   = busy & conv_done;
    assign at_last  = (idx == eff_last);

    inj_offset_sat #(.DW(DW)) u_sat (
        .raw    (conv_data),
        .offset (off_arr[idx]),
        .res    (cfg_res),
        .result (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
            eoc  <= 1'b0;
            eog  <= 1'b0;
        end else begin
            eoc <= accept;
            eog <= (accept & at_last) | (eog & ~eog_clr);
            if (accept) begin
                if (at_last) begin
                    idx  <= '0;
                    busy <= 1'b0;
                end else begin
                    idx <= idx + 1'b1;
                    if (disc_eff) busy <= 1'b0;
                end
            end else if (start) begin
                busy <= 1'b1;
                idx  <= (disc_eff && idx <= eff_last) ? idx : '0;
            end
        end
    end

    for (genvar r = 0; r < NRANK; r++) begin : g_rank
        logic [DW-1:0] data_q;
        assign chan_arr[r] = cfg_chan[r*CH_W +: CH_W];
        assign off_arr[r]  = cfg_offset[r*DW +: DW];
        always_ff @(posedge clk) begin
            if (rst)                                     data_q <= '0;
            else if (accept && idx == LEN_W'(r))         data_q <= result;
        end
        assign data_out[r*DW +: DW] = data_q;
    end

    assign conv_req  = busy;
    assign conv_chan = chan_arr[idx];
endmodule

// File: rtl/inj_seq_chk.sv
module inj_seq_chk (
    input logic clk,
    input logic rst,
    input logic conv_req,
    input logic conv_done,
    input logic eoc,
    input logic eog,
    input logic eog_clr,
    input logic cfg_scan,
    input logic cfg_cont,
    input logic cfg_disc
);
    // R10
    eoc_follows_done_chk: assert property (@(posedge clk) disable iff (rst)
        eoc |-> $past(conv_req && conv_done));

    // R10
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_done) |=> conv_req);

    // R11
    eog_needs_eoc_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(eog) |-> eoc);

    // R11
    eog_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (eog_clr && !conv_done) |=> !eog);

    // R5
    disc_one_rank_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_req && conv_done && cfg_disc && cfg_scan && !cfg_cont) |=> !conv_req);

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        $fell(rst) |-> (!conv_req && !eog && !eoc));
endmodule

bind adc_inj_sequencer inj_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .conv_req  (conv_req),
    .conv_done (conv_done),
    .eoc       (eoc),
    .eog       (eog),
    .eog_clr   (eog_clr),
    .cfg_scan  (cfg_scan),
    .cfg_cont  (cfg_cont),
    .cfg_disc  (cfg_disc)
);

// File: tb/sim_adc_inj_sequencer.sv
module sim_adc_inj_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int NRANK = 4;
    localparam int NSRC  = 4;
    localparam int DW    = 12;
    localparam int CH_W  = 5;
    localparam int SW_CODE = NSRC;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [1:0]            cfg_len_m1 = 2'd3;
    logic [NRANK*CH_W-1:0] cfg_chan;
    logic [NRANK*DW-1:0]   cfg_offset;
    logic [1:0]            cfg_res = 2'b00;
    logic [2:0]            cfg_src = 3'(SW_CODE);
    logic [1:0]            cfg_edge = 2'b00;
    logic                  cfg_scan = 1'b1;
    logic                  cfg_cont = 1'b0;
    logic                  cfg_disc = 1'b0;
    logic                  cfg_auto = 1'b0;
    logic [NSRC-1:0]       ext_trig = '0;
    logic                  sw_start = 1'b0;
    logic                  reg_done = 1'b0;
    logic                  conv_req;
    logic [CH_W-1:0]       conv_chan;
    logic                  conv_done = 1'b0;
    logic [DW-1:0]         conv_data = '0;
    logic [NRANK*DW-1:0]   data_out;
    logic                  eoc;
    logic                  eog;
    logic                  eog_clr = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int eoc_seen = 0;
    int chans [NRANK] = '{2, 7, 12, 17};
    int offs  [NRANK] = '{'h010, 'hFFF, 'h000, 'h123};

    adc_inj_sequencer u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        for (int r = 0; r < NRANK; r++) begin
            cfg_chan[r*CH_W +: CH_W] = CH_W'(chans[r]);
            cfg_offset[r*DW +: DW]   = DW'(offs[r]);
        end
    end

    // conversion engine: answers three cycles after seeing a request
    int eng_cnt = 0;
    int eng_k   = 0;
    always @(negedge clk) begin
        if (conv_done) begin
            conv_done <= 1'b0;
            eng_cnt = 0;
        end else if (conv_req) begin
            if (eng_cnt == 2) begin
                conv_done <= 1'b1;
                conv_data <= DW'((int'(conv_chan) * 97 + eng_k * 131) & 'hFFF);
                eng_k++;
            end else begin
                eng_cnt++;
            end
        end
    end

    // behavioural reference: a queue of pending ranks
    int q[$];
    int m_ptr, m_data [NRANK];
    bit m_eoc, m_eog, s1, s2, s3;

    function automatic int sat(int raw, int off, int res);
        int mask = 'hFFF >> (2 * res);
        int a = raw & mask;
        int b = off & mask;
        return (a > b) ? a - b : 0;
    endfunction

    always @(posedge clk) begin
        bit sw_sel, edge_ok, fire, disc_eff, auto_go, set_eog;
        int last, r;
        if (rst) begin
            q.delete();
            m_ptr = 0; m_eoc = 0; m_eog = 0; s1 = 0; s2 = 0; s3 = 0;
            for (int i = 0; i < NRANK; i++) m_data[i] = 0;
        end else begin
            sw_sel = (int'(cfg_src) == SW_CODE);
            case (cfg_edge)
                2'b01:   edge_ok = s2 && !s3;
                2'b10:   edge_ok = !s2 && s3;
                2'b11:   edge_ok = s2 != s3;
                default: edge_ok = 0;
            endcase
            fire     = sw_sel ? sw_start : edge_ok;
            disc_eff = cfg_disc && cfg_scan && !cfg_cont;
            last     = cfg_scan ? int'(cfg_len_m1) : 0;
            auto_go  = cfg_auto && sw_sel && !disc_eff && reg_done;
            set_eog  = 0;
            m_eoc    = 0;
            if (q.size() > 0 && conv_done) begin
                r = q.pop_front();
                m_data[r] = sat(int'(conv_data), offs[r], int'(cfg_res));
                m_eoc = 1;
                if (r == last) set_eog = 1;
                m_ptr = (r == last) ? 0 : r + 1;
            end else if (q.size() == 0 && (fire || auto_go)) begin
                if (disc_eff) q.push_back((m_ptr <= last) ? m_ptr : 0);
                else for (int i = 0; i <= last; i++) q.push_back(i);
            end
            m_eog = set_eog || (m_eog && !eog_clr);
            s3 = s2; s2 = s1;
            s1 = (int'(cfg_src) < NSRC) ? ext_trig[cfg_src[1:0]] : 1'b0;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            check("R1 conv_req", int'(conv_req), int'(q.size() > 0));
            if (q.size() > 0) check("R1 conv_chan", int'(conv_chan), chans[q[0]]);
            check("R10 eoc", int'(eoc), int'(m_eoc));
            check("R11 eog", int'(eog), int'(m_eog));
            for (int r = 0; r < NRANK; r++)
                check("R9 data", int'(data_out[r*DW +: DW]), m_data[r]);
            if (eoc) eoc_seen++;
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sw();
        sw_start = 1'b1; cycles(1); sw_start = 1'b0;
    endtask

    task automatic window(int n, int exp, string tag);
        cycles(n);
        check(tag, eoc_seen, exp);
        eoc_seen = 0;
    endtask

    task automatic clear_eog();
        eog_clr = 1'b1; cycles(1); eog_clr = 1'b0; cycles(1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        cycles(3);
        rst = 1'b0;
        cycles(1);
        // R12 reset state
        check("R12 req", int'(conv_req), 0);
        check("R12 eog", int'(eog), 0);
        check("R12 data", int'(data_out != '0), 0);
        eoc_seen = 0;

        // R1 full group by software, every length
        for (int l = 0; l < 4; l++) begin
            cfg_len_m1 = 2'(l);
            pulse_sw();
            window(30, l + 1, "R1 group length");
            check("R11 eog set", int'(eog), 1);
            clear_eog();
            check("R11 eog cleared", int'(eog), 0);
        end

        // R4 start while busy
        pulse_sw(); cycles(3); pulse_sw();
        window(30, 4, "R4 busy start ignored");
        clear_eog();

        // R2 external edges on line 1
        cfg_len_m1 = 2'd2; cfg_src = 3'd1; cfg_edge = 2'b01;
        ext_trig[1] = 1'b1; window(30, 3, "R2 rising starts");
        ext_trig[1] = 1'b0; window(30, 0, "R2 falling ignored in rise mode");
        cfg_edge = 2'b10;
        ext_trig[1] = 1'b1; window(30, 0, "R2 rising ignored in fall mode");
        ext_trig[1] = 1'b0; window(30, 3, "R2 falling starts");
        cfg_edge = 2'b11;
        ext_trig[1] = 1'b1; window(30, 3, "R2 either edge rise");
        ext_trig[1] = 1'b0; window(30, 3, "R2 either edge fall");
        ext_trig[1] = 1'b1; cycles(5); ext_trig[1] = 1'b0;
        window(30, 3, "R4 edge during group ignored");
        cfg_edge = 2'b00;
        ext_trig[1] = 1'b1; window(30, 0, "R2 edge off");
        ext_trig[1] = 1'b0; cycles(5);
        cfg_edge = 2'b01;
        ext_trig[2] = 1'b1; window(30, 0, "R2 unselected line");
        ext_trig[2] = 1'b0;

        // R3 source selection
        pulse_sw(); window(30, 0, "R3 sw_start ignored for external source");
        cfg_src = 3'(SW_CODE);
        ext_trig[1] = 1'b1; window(30, 0, "R3 external ignored in software mode");
        ext_trig[1] = 1'b0; cycles(5);
        clear_eog();

        // R5 discontinuous stepping with wrap
        cfg_disc = 1'b1;
        for (int t = 0; t < 4; t++) begin
            pulse_sw();
            window(20, 1, "R5 one rank per start");
        end
        // R6 continuous overrides discontinuous
        cfg_cont = 1'b1;
        pulse_sw(); window(30, 3, "R6 disc ignored with cont");
        // R7 scan off
        cfg_cont = 1'b0; cfg_scan = 1'b0;
        pulse_sw(); window(20, 1, "R7 scan off converts rank 0 only");
        cfg_scan = 1'b1; cfg_disc = 1'b0;
        clear_eog();

        // R8 automatic chaining
        cfg_auto = 1'b0; cfg_len_m1 = 2'd3;
        reg_done = 1'b1; cycles(1); reg_done = 1'b0;
        window(30, 0, "R8 reg_done without auto");
        cfg_auto = 1'b1;
        reg_done = 1'b1; cycles(1); reg_done = 1'b0;
        window(30, 4, "R8 auto chain");
        cfg_src = 3'd0;
        reg_done = 1'b1; cycles(1); reg_done = 1'b0;
        window(30, 0, "R8 auto blocked by external source");
        cfg_src = 3'(SW_CODE); cfg_disc = 1'b1;
        reg_done = 1'b1; cycles(1); reg_done = 1'b0;
        window(30, 0, "R8 auto blocked by disc");
        cfg_disc = 1'b0; cfg_auto = 1'b0;

        // R9 every resolution
        for (int s = 0; s < 4; s++) begin
            cfg_res = 2'(s);
            pulse_sw();
            window(30, 4, "R9 group at resolution");
            check("R9 full-scale offset clamps", int'(data_out[DW +: DW]), 0);
        end

        // R11 set wins over clear
        eog_clr = 1'b1; pulse_sw(); cycles(25);
        check("R11 set wins over clear", int'(eog), 0);
        eog_clr = 1'b0;
        eoc_seen = 0;
        cycles(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule